// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small accumulator processor. A 4-bit microprogram counter addresses a 16-word microcode store. Each word holds thirteen datapath strobes, a 2-bit sequencing test code and a 4-bit branch target. The strobes are driven straight from the word at the current microaddress, so the datapath sees each micro-operation during the whole cycle in which the counter holds that address.

The next microaddress is formed by a single 4-bit adder. Its base is the current address, the branch target or the opcode. Its increment is 1, 0 or 3. This one adder covers stepping, branching and opcode dispatch. Every instruction runs a common fetch prefix at addresses 0 to 2. It then dispatches to an opcode entry at 3 to 10, passes through the shared tails at 10 to 14, and finishes back at address 0.

Top module: `useq_ctrl`

## Requirements
- R1: A high `rst` at a rising clock edge sets `upc` to 0 at that edge.
- R2: When `seq_test` is 2'b00, the next `upc` is the current `upc` plus 1.
- R3: When `seq_test` is 2'b10, the next `upc` is `opcode` + 3.
- R4: When `seq_test` is 2'b01, the next `upc` is the branch target if `acc_nz` is 1, and the current `upc` plus 1 if `acc_nz` is 0. Only address 3 uses this code, with target 10.
- R5: When `seq_test` is 2'b11, the next `upc` is the branch target. The targets are: address 4 to 0, 5 to 12, 6 to 13, 7 to 10, 8 to 10, 11 to 0, 12 to 14, 14 to 10.
- R6: The fetch strobes are as follows. Address 0 asserts `pc_oe` and `mar_ld`. Address 1 asserts `mem_rd` and `ir_ld`. Address 2 asserts `ir_oe` and `mar_ld`.
- R7: The opcode entries drive these strobes. Address 3 asserts none. Address 4 asserts `ir_oe` and `pc_ld`. Addresses 5 and 6 assert `acc_oe` and `arg_ld`. Address 7 asserts `mem_rd` and `acc_ld`. Address 8 asserts `acc_oe` and `mem_wr`. Address 9 asserts none.
- R8: The tail entries drive these strobes. Address 10 asserts `pc_oe` with increment. Address 11 asserts `buf_oe` and `pc_ld`. Address 12 asserts `mem_rd` with add. Address 13 asserts `mem_rd` with subtract. Address 14 asserts `buf_oe` and `acc_ld`.
- R9: `alu_fn` is 2'b01 only at the subtract step (address 13) and 2'b10 only at the increment step (address 10). Everywhere else it is 2'b00, which means add. It is never 2'b11.
- R10: At most one of `mem_rd`, `pc_oe`, `acc_oe`, `ir_oe` and `buf_oe` is high in any cycle.
- R11: `seq_test` shows the test code of the current word. The codes are: 00 at addresses 0, 1, 9, 10 and 13; 10 at address 2; 01 at address 3; 11 at addresses 4 to 8, 11, 12, 14 and 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_nz | input | 1 | Accumulator is nonzero |
| opcode | input | 3 | Current instruction opcode |
| mem_wr | output | 1 | Write memory from the bus |
| mem_rd | output | 1 | Memory drives the bus |
| mar_ld | output | 1 | Load address register |
| pc_ld | output | 1 | Load program counter |
| pc_oe | output | 1 | Program counter drives the bus |
| acc_ld | output | 1 | Load accumulator |
| acc_oe | output | 1 | Accumulator drives the bus |
| ir_ld | output | 1 | Load instruction register |
| ir_oe | output | 1 | Instruction register drives the bus |
| arg_ld | output | 1 | Load ALU argument register |
| alu_fn | output | 2 | ALU function: bit 0 subtract, bit 1 increment |
| buf_oe | output | 1 | ALU result buffer drives the bus |
| upc | output | 4 | Current microaddress |
| seq_test | output | 2 | Test code of the current word |

## Verification
The strobes, `alu_fn` and `seq_test` depend only on `upc`. They are therefore valid for the whole cycle in which `upc` holds an address. `opcode` and `acc_nz` take effect one rising edge later, when `upc` takes its next value. The bench changes inputs just after a rising edge and compares all outputs at the following falling edge. The scoreboard holds one expected item per cycle, with the predicted address and its strobes. Reset is checked at the falling edge after the first edge on which `rst` is high.

// File: rtl/useq_ctrl.sv
module useq_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       acc_nz,
  input  logic [2:0] opcode,
  output logic       mem_wr,
  output logic       mem_rd,
  output logic       mar_ld,
  output logic       pc_ld,
  output logic       pc_oe,
  output logic       acc_ld,
  output logic       acc_oe,
  output logic       ir_ld,
  output logic       ir_oe,
  output logic       arg_ld,
  output logic [1:0] alu_fn,
  output logic       buf_oe,
  output logic [3:0] upc,
  output logic [1:0] seq_test
);
  localparam int AW = 4;
  localparam int SW = 13;

  localparam logic [SW-1:0] MW  = 13'h1000;
  localparam logic [SW-1:0] MR  = 13'h0800;
  localparam logic [SW-1:0] MAL = 13'h0400;
  localparam logic [SW-1:0] PL  = 13'h0200;
  localparam logic [SW-1:0] PO  = 13'h0100;
  localparam logic [SW-1:0] AL  = 13'h0080;
  localparam logic [SW-1:0] AO  = 13'h0040;
  localparam logic [SW-1:0] IL  = 13'h0020;
  localparam logic [SW-1:0] IO  = 13'h0010;
  localparam logic [SW-1:0] GL  = 13'h0008;
  localparam logic [SW-1:0] INC = 13'h0004;
  localparam logic [SW-1:0] SUB = 13'h0002;
  localparam logic [SW-1:0] BO  = 13'h0001;

  localparam logic [1:0] T_STEP = 2'b00;
  localparam logic [1:0] T_BNZ  = 2'b01;
  localparam logic [1:0] T_DISP = 2'b10;
  localparam logic [1:0] T_JMP  = 2'b11;

  logic [SW-1:0] strb;
  logic [1:0]    tst;
  logic [AW-1:0] tgt;
  logic [AW-1:0] mpc;

  always_comb begin
    strb = '0;
    tst  = T_JMP;
    tgt  = '0;
    case (mpc)
      4'd0:  begin strb = PO | MAL; tst = T_STEP; end
      4'd1:  begin strb = MR | IL;  tst = T_STEP; end
      4'd2:  begin strb = IO | MAL; tst = T_DISP; end
      4'd3:  begin tst = T_BNZ; tgt = 4'd10; end
      4'd4:  begin strb = IO | PL; end
      4'd5:  begin strb = AO | GL; tgt = 4'd12; end
      4'd6:  begin strb = AO | GL; tgt = 4'd13; end
      4'd7:  begin strb = MR | AL; tgt = 4'd10; end
      4'd8:  begin strb = AO | MW; tgt = 4'd10; end
      4'd9:  begin tst = T_STEP; end
      4'd10: begin strb = PO | INC; tst = T_STEP; end
      4'd11: begin strb = BO | PL; end
      4'd12: begin strb = MR; tgt = 4'd14; end
      4'd13: begin strb = MR | SUB; tst = T_STEP; end
      4'd14: begin strb = BO | AL; tgt = 4'd10; end
      default: begin end
    endcase
  end

  logic          take;
  logic [AW-1:0] base, incr;

  assign take = tst[1] | (tst[0] & acc_nz);
  assign base = !take ? mpc : (tst[0] ? tgt : {1'b0, opcode});
  assign incr = !take ? 4'd1 : (tst[0] ? 4'd0 : 4'd3);

  always_ff @(posedge clk) begin
    if (rst) mpc <= '0;
    else     mpc <= base + incr;
  end

  assign {mem_wr, mem_rd, mar_ld, pc_ld, pc_oe, acc_ld, acc_oe,
          ir_ld, ir_oe, arg_ld, alu_fn, buf_oe} = strb;
  assign upc      = mpc;
  assign seq_test = tst;

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> upc == 4'd0);
  // R2
  step_next_chk: assert property (@(posedge clk) disable iff (rst)
    seq_test == T_STEP |=> upc == $past(upc) + 4'd1);
  // R3
  dispatch_chk: assert property (@(posedge clk) disable iff (rst)
    seq_test == T_DISP |=> upc == {1'b0, $past(opcode)} + 4'd3);
  // R4
  bnz_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_test == T_BNZ && !acc_nz) |=> upc == $past(upc) + 4'd1);
  // R4
  bnz_take_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_test == T_BNZ && acc_nz) |=> upc == 4'd10);
  // R9
  alu_code_chk: assert property (@(posedge clk) disable iff (rst)
    alu_fn != 2'b11);
  // R10
  one_driver_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, pc_oe, acc_oe, ir_oe, buf_oe}));
endmodule

// File: tb/useq_ctrl_test.sv
module useq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, acc_nz = 0;
  logic [2:0] opcode = 0;
  logic mem_wr, mem_rd, mar_ld, pc_ld, pc_oe, acc_ld, acc_oe;
  logic ir_ld, ir_oe, arg_ld, buf_oe;
  logic [1:0] alu_fn, seq_test;
  logic [3:0] upc;

  int checks = 0, errors = 0;
  bit done = 0;

  useq_ctrl uut (.clk(clk), .rst(rst), .acc_nz(acc_nz), .opcode(opcode),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mar_ld(mar_ld), .pc_ld(pc_ld),
    .pc_oe(pc_oe), .acc_ld(acc_ld), .acc_oe(acc_oe), .ir_ld(ir_ld),
    .ir_oe(ir_oe), .arg_ld(arg_ld), .alu_fn(alu_fn), .buf_oe(buf_oe),
    .upc(upc), .seq_test(seq_test));

  always #(CLK_PERIOD/2) clk = ~clk;

  // strobe order: mem_wr mem_rd mar_ld pc_ld pc_oe acc_ld acc_oe ir_ld ir_oe arg_ld alu_fn[1:0] buf_oe
  function automatic logic [12:0] exp_strb(int a);
    case (a)
      0:  return 13'h0100 | 13'h0400;
      1:  return 13'h0800 | 13'h0020;
      2:  return 13'h0010 | 13'h0400;
      4:  return 13'h0010 | 13'h0200;
      5, 6: return 13'h0040 | 13'h0008;
      7:  return 13'h0800 | 13'h0080;
      8:  return 13'h0040 | 13'h1000;
      10: return 13'h0100 | 13'h0004;
      11: return 13'h0001 | 13'h0200;
      12: return 13'h0800;
      13: return 13'h0800 | 13'h0002;
      14: return 13'h0001 | 13'h0080;
      default: return 13'h0000;
    endcase
  endfunction

  function automatic logic [1:0] exp_test(int a);
    case (a)
      0, 1, 9, 10, 13: return 2'b00;
      2: return 2'b10;
      3: return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  int    q_addr[$];
  string q_tag[$];

  task automatic push(int a, string tag);
    q_addr.push_back(a);
    q_tag.push_back(tag);
  endtask

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor: compares each cycle against the next scoreboard item
  always @(negedge clk) begin
    if (!rst && q_addr.size() > 0) begin
      int a;
      string tg;
      logic [12:0] s;
      a  = q_addr.pop_front();
      tg = q_tag.pop_front();
      s  = {mem_wr, mem_rd, mar_ld, pc_ld, pc_oe, acc_ld, acc_oe,
            ir_ld, ir_oe, arg_ld, alu_fn, buf_oe};
      check(upc == a[3:0], tg, upc, a);
      check(s == exp_strb(a), a < 3 ? "R6" : (a < 10 ? "R7" : "R8"), s, exp_strb(a));
      check(seq_test == exp_test(a), "R11", seq_test, exp_test(a));
      check(alu_fn == (a == 13 ? 2'b01 : (a == 10 ? 2'b10 : 2'b00)), "R9",
            alu_fn, a == 13 ? 1 : (a == 10 ? 2 : 0));
      check($countones({mem_rd, pc_oe, acc_oe, ir_oe, buf_oe}) <= 1, "R10",
            $countones({mem_rd, pc_oe, acc_oe, ir_oe, buf_oe}), 1);
    end
  end

  // driver: predicts the microaddress path of one instruction
  task automatic run_instr(logic [2:0] op, logic nz, string first_tag);
    int n0;
    n0 = q_addr.size();
    push(0, first_tag); push(1, "R2"); push(2, "R2");
    case (op)
      3'd0: if (nz) begin push(3, "R3"); push(10, "R4"); push(11, "R2"); end
            else    begin push(3, "R3"); push(4, "R4"); end
      3'd1: push(4, "R3");
      3'd2: begin push(5, "R3"); push(12, "R5"); push(14, "R5"); push(10, "R5"); push(11, "R2"); end
      3'd3: begin push(6, "R3"); push(13, "R5"); push(14, "R2"); push(10, "R5"); push(11, "R2"); end
      3'd4: begin push(7, "R3"); push(10, "R5"); push(11, "R2"); end
      3'd5: begin push(8, "R3"); push(10, "R5"); push(11, "R2"); end
      3'd6: begin push(9, "R3"); push(10, "R2"); push(11, "R2"); end
      default: begin push(10, "R3"); push(11, "R2"); end
    endcase
    opcode = op;
    acc_nz = nz;
    repeat (q_addr.size() - n0) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(upc == 4'd0, "R1", upc, 0);
    check({mem_rd, ir_ld, mem_wr} == 3'b000, "R6", {mem_rd, ir_ld, mem_wr}, 0);
    @(posedge clk); #1;
    rst = 0;
    run_instr(3'd0, 1'b1, "R1");
    run_instr(3'd0, 1'b0, "R5");
    for (int i = 1; i < 8; i++) run_instr(i[2:0], i[0], "R5");
    run_instr(3'd0, 1'b1, "R5");
    run_instr(3'd2, 1'b0, "R5");
    @(negedge clk);
    check(q_addr.size() == 0, "R2", q_addr.size(), 0);
    opcode = 3'd3;
    repeat (3) @(posedge clk);
    #1;
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    check(upc == 4'd0, "R1", upc, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule